// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences entry into and exit from low-power states for a small microcontroller core. The CPU supplies a two-bit mode field, a sleep-enable bit and a one-cycle strobe that marks execution of the sleep instruction. When the strobe is accepted, the block lowers the clock enables of the domains that the chosen mode stops. These domains are the CPU, flash, I/O and ADC clocks and the oscillator. It records the mode, and for the two modes that keep the converter clocked it can fire a single-cycle conversion start.

While asleep, the block watches individual interrupt and reset inputs. It passes only those that the recorded mode allows to wake the core. A qualifying interrupt brings the core back. When the oscillator had been stopped, the block first turns it on and waits a programmable number of cycles. It then raises every clock enable together and gives the CPU a one-cycle wake strobe. A reset source returns the block to the running state from any sleep state, without a wake strobe.

Top module: `slp_pwr_ctrl`

## Requirements
- R1: When `sleep_req` is high and `sleep_en` is set while running, the block enters the mode given by `mode_sel` at the next clock edge. The mode codes are 00 Idle, 01 converter quiet mode, 10 Power-down and 11 Stand-by.
- R2: When `sleep_req` is high with `sleep_en` clear, nothing changes: all five enables stay high.
- R3: In Idle, `cpu_clk_en` and `flash_clk_en` are low, and `io_clk_en`, `adc_clk_en` and `osc_en` are high.
- R4: In converter quiet mode, the CPU, flash and I/O enables are low, and `adc_clk_en` and `osc_en` are high.
- R5: In Power-down, all four clock enables and `osc_en` are low.
- R6: In Stand-by, all four clock enables are low and `osc_en` stays high.
- R7: `adc_start` is high for exactly the one cycle after entry into Idle or converter quiet mode, and only if `adc_on` was high at the strobe. It never fires on entry into Power-down or Stand-by.
- R8: In Idle, any one of `irq_other`, `irq_adc_done`, `irq_nvm_rdy`, `irq_ext_lvl` and `irq_pin_chg` wakes the core.
- R9: In converter quiet mode, `irq_adc_done`, `irq_nvm_rdy`, `irq_ext_lvl` and `irq_pin_chg` wake the core. `irq_other` has no effect.
- R10: In Power-down and Stand-by, only `irq_ext_lvl` and `irq_pin_chg` wake the core. The other three interrupt inputs have no effect.
- R11: On a wake from Power-down, `osc_en` rises at the edge that samples the wake source. The clock enables and `wake_pulse` rise exactly `STARTUP_CYC` edges later.
- R12: On a wake from Idle, converter quiet mode or Stand-by, all five enables and `wake_pulse` are high after the edge that samples the wake source.
- R13: While asleep or warming up, any of `rst_ext`, `rst_wdt` and `rst_bod` returns all enables high at the next edge, with `wake_pulse` low. A sleep strobe in the same cycle as a reset source is ignored.
- R14: `wake_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Requested sleep mode code |
| sleep_en | input | 1 | Permits the sleep strobe to take effect |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| adc_on | input | 1 | Converter is enabled |
| irq_other | input | 1 | Any other enabled interrupt (timers, comparator) |
| irq_adc_done | input | 1 | Conversion complete interrupt |
| irq_nvm_rdy | input | 1 | Flash/EEPROM ready interrupt |
| irq_ext_lvl | input | 1 | External level interrupt |
| irq_pin_chg | input | 1 | Pin-change interrupt |
| rst_ext | input | 1 | External reset source |
| rst_wdt | input | 1 | Watchdog reset source |
| rst_bod | input | 1 | Brown-out reset source |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| osc_en | output | 1 | Oscillator enable |
| adc_start | output | 1 | One-cycle conversion start request |
| wake_pulse | output | 1 | One-cycle wake strobe to the CPU |

## Verification
Two events can fall in the same cycle. A reset source can arrive with a sleep strobe, and a reset source can arrive in the middle of the oscillator warm-up that a wake has started. The bench provokes the first by raising `rst_ext` in the cycle that carries an accepted sleep strobe. It provokes the second by raising `rst_bod` one cycle after a pin-change wake from Power-down. In both cases the reset must win: all enables high at the next edge, no entry into sleep, and no wake strobe, either then or when the abandoned warm-up count would have ended.

// File: rtl/slp_pkg.sv
// Shared types and mode helpers for the sleep controller.
// Assumes the two-bit mode code order is fixed by the CPU's control field.
package slp_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCNR = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_STBY  = 2'b11
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_DOZE = 2'b01,
        ST_WARM = 2'b10
    } slp_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } clk_en_t;

    typedef struct packed {
        logic other;
        logic adc_done;
        logic nvm_rdy;
        logic ext_lvl;
        logic pin_chg;
    } wake_src_t;

    localparam int WAKE_SRC_N = $bits(wake_src_t);

    // Oscillator is switched off only in Power-down.
    function automatic logic mode_stops_osc(slp_mode_e m);
        return (m == MODE_PDOWN);
    endfunction

    // Modes on whose entry the converter is started automatically.
    function automatic logic mode_auto_adc(slp_mode_e m);
        return (m == MODE_IDLE) || (m == MODE_ADCNR);
    endfunction

    // Wake sources accepted per mode, one bit per wake_src_t field.
    function automatic wake_src_t mode_wake_mask(slp_mode_e m);
        wake_src_t k;
        k = '0;
        k.ext_lvl = 1'b1;
        k.pin_chg = 1'b1;
        if (m == MODE_IDLE || m == MODE_ADCNR) begin
            k.adc_done = 1'b1;
            k.nvm_rdy  = 1'b1;
        end
        if (m == MODE_IDLE) begin
            k.other = 1'b1;
        end
        return k;
    endfunction

endpackage

// File: rtl/slp_wake_filter.sv
// Wake and reset qualifier.
// Reduces the interrupt inputs to one wake hit, using the mask of the
// recorded mode, and the reset sources to one reset hit.
// Assumes the inputs are already synchronous to clk.
module slp_wake_filter
    import slp_pkg::*;
(
    input  slp_mode_e mode,
    input  wake_src_t src,
    input  logic      rst_ext,
    input  logic      rst_wdt,
    input  logic      rst_bod,
    output logic      wake_hit,
    output logic      rst_hit
);

    wake_src_t mask;
    logic [WAKE_SRC_N-1:0] passed;

    // Mask lookup for the current mode.
    always_comb mask = mode_wake_mask(mode);

    // Per-source gating, one lane per wake input.
    for (genvar i = 0; i < WAKE_SRC_N; i++) begin : g_lane
        assign passed[i] = src[i] & mask[i];
    end

    // Collapse lanes and reset sources into single hits.
    always_comb begin
        wake_hit = |passed;
        rst_hit  = rst_ext | rst_wdt | rst_bod;
    end

endmodule

// File: rtl/slp_clk_decode.sv
// Clock-domain enable decoder.
// Maps the sequencer state and the recorded mode to the five enables.
// Assumes the warm-up state is only reached from Power-down.
module slp_clk_decode
    import slp_pkg::*;
(
    input  slp_state_e state,
    input  slp_mode_e  mode,
    output clk_en_t    en
);

    // Enable table by state, then by mode.
    always_comb begin
        en = '1;
        case (state)
            ST_RUN: en = '1;
            ST_DOZE: begin
                case (mode)
                    MODE_IDLE:  en = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
                    MODE_ADCNR: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
                    MODE_PDOWN: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
                    default:    en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
                endcase
            end
            ST_WARM: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
            default: en = '1;
        endcase
    end

endmodule

// File: rtl/slp_seq.sv
// Sleep sequencer.
// Accepts the sleep strobe, holds the mode, and runs the oscillator warm-up
// count. Emits the conversion start and wake strobes.
// Assumes STARTUP_CYC >= 1.
module slp_seq
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       sleep_en,
    input  slp_mode_e  req_mode,
    input  logic       adc_on,
    input  logic       wake_hit,
    input  logic       rst_hit,
    output slp_state_e state,
    output slp_mode_e  mode_q,
    output logic       adc_start,
    output logic       wake_pulse
);

    localparam int CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STARTUP_CYC - 1);

    logic [CNT_W-1:0] warm_cnt;

    // State, mode register, warm-up counter and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            mode_q     <= MODE_IDLE;
            warm_cnt   <= '0;
            adc_start  <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            adc_start  <= 1'b0;
            wake_pulse <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_req && sleep_en && !rst_hit) begin
                        state     <= ST_DOZE;
                        mode_q    <= req_mode;
                        adc_start <= adc_on && mode_auto_adc(req_mode);
                    end
                end
                ST_DOZE: begin
                    if (rst_hit) begin
                        state <= ST_RUN;
                    end else if (wake_hit) begin
                        if (mode_stops_osc(mode_q)) begin
                            state    <= ST_WARM;
                            warm_cnt <= CNT_LOAD;
                        end else begin
                            state      <= ST_RUN;
                            wake_pulse <= 1'b1;
                        end
                    end
                end
                ST_WARM: begin
                    if (rst_hit) begin
                        state <= ST_RUN;
                    end else if (warm_cnt == '0) begin
                        state      <= ST_RUN;
                        wake_pulse <= 1'b1;
                    end else begin
                        warm_cnt <= warm_cnt - 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

endmodule

// File: rtl/slp_pwr_ctrl.sv
// Sleep mode power controller, top level.
// Joins the wake qualifier, the sequencer and the enable decoder.
// Assumes all inputs are synchronous to clk and the reset is synchronous.
module slp_pwr_ctrl
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       sleep_en,
    input  logic       sleep_req,
    input  logic       adc_on,
    input  logic       irq_other,
    input  logic       irq_adc_done,
    input  logic       irq_nvm_rdy,
    input  logic       irq_ext_lvl,
    input  logic       irq_pin_chg,
    input  logic       rst_ext,
    input  logic       rst_wdt,
    input  logic       rst_bod,
    output logic       cpu_clk_en,
    output logic       flash_clk_en,
    output logic       io_clk_en,
    output logic       adc_clk_en,
    output logic       osc_en,
    output logic       adc_start,
    output logic       wake_pulse
);

    wake_src_t  src;
    slp_state_e state;
    slp_mode_e  mode_q;
    clk_en_t    en;
    logic       wake_hit;
    logic       rst_hit;

    // Gather the interrupt inputs into one record.
    always_comb begin
        src.other    = irq_other;
        src.adc_done = irq_adc_done;
        src.nvm_rdy  = irq_nvm_rdy;
        src.ext_lvl  = irq_ext_lvl;
        src.pin_chg  = irq_pin_chg;
    end

    slp_wake_filter u_filter (
        .mode     (mode_q),
        .src      (src),
        .rst_ext  (rst_ext),
        .rst_wdt  (rst_wdt),
        .rst_bod  (rst_bod),
        .wake_hit (wake_hit),
        .rst_hit  (rst_hit)
    );

    slp_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .sleep_en   (sleep_en),
        .req_mode   (slp_mode_e'(mode_sel)),
        .adc_on     (adc_on),
        .wake_hit   (wake_hit),
        .rst_hit    (rst_hit),
        .state      (state),
        .mode_q     (mode_q),
        .adc_start  (adc_start),
        .wake_pulse (wake_pulse)
    );

    slp_clk_decode u_decode (
        .state (state),
        .mode  (mode_q),
        .en    (en)
    );

    // Fan the enable record out to the ports.
    always_comb begin
        cpu_clk_en   = en.cpu;
        flash_clk_en = en.flash;
        io_clk_en    = en.io;
        adc_clk_en   = en.adc;
        osc_en       = en.osc;
    end

endmodule

// File: rtl/slp_pwr_ctrl_chk.sv
// Property checker for the sleep controller, bound to the top level.
// Observes ports only. cpu_clk_en high is taken as "running".
module slp_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       sleep_en,
    input logic       sleep_req,
    input logic       rst_ext,
    input logic       rst_wdt,
    input logic       rst_bod,
    input logic       cpu_clk_en,
    input logic       flash_clk_en,
    input logic       io_clk_en,
    input logic       adc_clk_en,
    input logic       osc_en,
    input logic       adc_start,
    input logic       wake_pulse
);

    logic any_rst;
    assign any_rst = rst_ext | rst_wdt | rst_bod;

    AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en && sleep_req && !sleep_en |=> cpu_clk_en && osc_en); // R2
    AST_IDLE_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en && sleep_req && sleep_en && !any_rst && mode_sel == 2'b00
        |=> !cpu_clk_en && !flash_clk_en && io_clk_en && adc_clk_en && osc_en); // R3
    AST_PDOWN_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en && sleep_req && sleep_en && !any_rst && mode_sel == 2'b10
        |=> !cpu_clk_en && !io_clk_en && !adc_clk_en && !osc_en); // R5
    AST_ADC_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R7
    AST_ADC_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !cpu_clk_en && adc_clk_en); // R7
    AST_OSC_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en && !osc_en && !any_rst |=> !cpu_clk_en); // R11
    AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> cpu_clk_en && flash_clk_en && io_clk_en && adc_clk_en && osc_en); // R12
    AST_RESET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en && any_rst |=> cpu_clk_en && osc_en && !wake_pulse); // R13
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R14

endmodule

bind slp_pwr_ctrl slp_pwr_ctrl_chk u_chk (.*);

// File: tb/slp_pwr_ctrl_test.sv
// Directed bench for the sleep controller: one task per scenario.
// Inputs change and outputs are sampled on the falling edge.
module slp_pwr_ctrl_test;

    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       sleep_en = 1'b0, sleep_req = 1'b0, adc_on = 1'b0;
    logic [4:0] irq = '0;   // {other, adc_done, nvm_rdy, ext_lvl, pin_chg}
    logic       rst_ext = 1'b0, rst_wdt = 1'b0, rst_bod = 1'b0;
    logic       cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_en;
    logic       adc_start, wake_pulse;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    slp_pwr_ctrl #(.STARTUP_CYC(N)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
        .sleep_req(sleep_req), .adc_on(adc_on),
        .irq_other(irq[4]), .irq_adc_done(irq[3]), .irq_nvm_rdy(irq[2]),
        .irq_ext_lvl(irq[1]), .irq_pin_chg(irq[0]),
        .rst_ext(rst_ext), .rst_wdt(rst_wdt), .rst_bod(rst_bod),
        .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
        .adc_clk_en(adc_clk_en), .osc_en(osc_en), .adc_start(adc_start),
        .wake_pulse(wake_pulse)
    );

    // {cpu, flash, io, adc, osc, adc_start, wake_pulse}
    function automatic logic [6:0] obs();
        return {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, osc_en, adc_start, wake_pulse};
    endfunction

    task automatic chk(input string tag, input logic [6:0] exp);
        total++;
        if (obs() !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, obs(), exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Issue an accepted sleep strobe; returns after the entry edge.
    task automatic enter(input logic [1:0] m, input logic a);
        tick();
        mode_sel = m; adc_on = a; sleep_en = 1'b1; sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
    endtask

    // Raise one interrupt input for one edge; returns after that edge.
    task automatic pulse_irq(input int idx);
        irq[idx] = 1'b1;
        tick();
        irq[idx] = 1'b0;
    endtask

    task automatic t_reset();
        tick();
        chk("R13 reset state", 7'b11111_00);
    endtask

    task automatic t_no_enable();
        sleep_en = 1'b0; sleep_req = 1'b1; mode_sel = 2'b10;
        tick();
        sleep_req = 1'b0;
        chk("R2 strobe without enable", 7'b11111_00);
        tick();
        chk("R2 still running", 7'b11111_00);
    endtask

    task automatic t_idle();
        for (int s = 0; s < 5; s++) begin
            enter(2'b00, 1'b1);
            chk("R3 R7 R1 idle entry", 7'b00111_10);
            tick();
            chk("R7 start is single", 7'b00111_00);
            pulse_irq(s);
            chk("R8 R12 idle wake", 7'b11111_01);
            tick();
            chk("R14 wake single", 7'b11111_00);
        end
        enter(2'b00, 1'b0);
        chk("R7 no start when adc off", 7'b00111_00);
        pulse_irq(1);
        chk("R8 idle wake ext", 7'b11111_01);
    endtask

    task automatic t_adcnr();
        enter(2'b01, 1'b1);
        chk("R4 R7 quiet entry", 7'b00011_10);
        pulse_irq(4);
        chk("R9 other irq ignored", 7'b00011_00);
        tick();
        chk("R9 still asleep", 7'b00011_00);
        pulse_irq(3);
        chk("R9 R12 conv done wakes", 7'b11111_01);
        enter(2'b01, 1'b0);
        chk("R4 R7 quiet no start", 7'b00011_00);
        pulse_irq(2);
        chk("R9 nvm ready wakes", 7'b11111_01);
    endtask

    task automatic t_pdown();
        enter(2'b10, 1'b1);
        chk("R5 R7 power-down entry", 7'b00000_00);
        for (int s = 2; s < 5; s++) begin
            pulse_irq(s);
            chk("R10 ignored in power-down", 7'b00000_00);
        end
        pulse_irq(0);
        chk("R11 osc first", 7'b00001_00);
        for (int k = 1; k < N; k++) begin
            tick();
            chk("R11 warm-up hold", 7'b00001_00);
        end
        tick();
        chk("R11 clocks back after delay", 7'b11111_01);
        tick();
        chk("R14 wake single", 7'b11111_00);
    endtask

    task automatic t_stby();
        enter(2'b11, 1'b1);
        chk("R6 R7 stand-by entry", 7'b00001_00);
        pulse_irq(3);
        chk("R10 conv done ignored", 7'b00001_00);
        pulse_irq(4);
        chk("R10 other ignored", 7'b00001_00);
        pulse_irq(1);
        chk("R12 stand-by quick wake", 7'b11111_01);
    endtask

    task automatic t_resets();
        enter(2'b10, 1'b0);
        rst_wdt = 1'b1;
        tick();
        rst_wdt = 1'b0;
        chk("R13 watchdog from power-down", 7'b11111_00);
        enter(2'b00, 1'b1);
        rst_ext = 1'b1;
        tick();
        rst_ext = 1'b0;
        chk("R13 external from idle", 7'b11111_00);
        // Collision: reset source in the strobe cycle.
        tick();
        mode_sel = 2'b10; sleep_en = 1'b1; sleep_req = 1'b1; rst_ext = 1'b1;
        tick();
        sleep_req = 1'b0; rst_ext = 1'b0;
        chk("R13 strobe with reset ignored", 7'b11111_00);
        // Collision: reset source during warm-up.
        enter(2'b10, 1'b0);
        pulse_irq(0);
        chk("R11 warm-up begins", 7'b00001_00);
        rst_bod = 1'b1;
        tick();
        rst_bod = 1'b0;
        chk("R13 brown-out during warm-up", 7'b11111_00);
        for (int k = 0; k < N + 1; k++) begin
            tick();
            chk("R13 no late wake", 7'b11111_00);
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_no_enable();
        t_idle();
        t_adcnr();
        t_pdown();
        t_stby();
        t_resets();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule